// File: doc/BRIEF.md
# Link Retrain Request Controller

This block sits between the configuration register write path of a port and its link training state machine. Software retrain commands, written as self-clearing bits, become single-cycle requests to enter training at one of two entry states. A link-retrain command sends training to Recovery. On an upstream-facing port it is honoured only while the register-unlock input is high. On a downstream-facing port it is always honoured. A full-retrain command sends training to Detect on either port type.

The block also tracks the current link speed, which is reported by the training state machine when training completes. It records when a retrain has lowered the speed from 5.0 Gbps to 2.5 Gbps. On a downstream-facing port that event sets a sticky, write-one-to-clear bandwidth-change status bit. On any port it holds the permitted speed at 2.5 Gbps. The hold lasts until the link partner asks for an upgrade, an accepted link-retrain command is issued, or a full retrain is issued. The status register image carries the current speed field and the status bit.

Speeds are encoded as 1 for 2.5 Gbps and 2 for 5.0 Gbps.

Top module: `lnk_retrain_ctrl`

## Requirements
- R1: On an upstream-type port (`port_dsp_i`=0), a link-control write with data bit 5 set raises `go_recovery_o` for one cycle after the write edge only if `reg_unlock_i` is 1; with the unlock low nothing is issued.
- R2: On a downstream-type port (`port_dsp_i`=1), a link-control write with data bit 5 set raises `go_recovery_o` one cycle after the write edge, whatever the value of `reg_unlock_i`.
- R3: A PHY-state write with data bit 0 set raises `go_detect_o` one cycle after the write edge, on either port type.
- R4: Both request outputs are single-cycle pulses that are never high together; a full retrain and a link retrain written in the same cycle issue only `go_detect_o`.
- R5: A training completion reporting speed 1 while the current speed is 2 sets the bandwidth-change status bit on a downstream-type port; on an upstream-type port the bit stays 0.
- R6: The bandwidth-change status bit is sticky and is cleared by a status-register write with data bit 15 set; a setting event in the same cycle as such a clear leaves the bit set.
- R7: After a downgrade, `speed_cap_o` reads 1. It returns to the target speed (2) one cycle after a partner upgrade request, or one cycle after an issued `go_recovery_o` or `go_detect_o` pulse.
- R8: `lsts_o[3:0]` holds the current speed: the target speed (2) after reset, and the speed carried by `train_speed_i` from the cycle after each `train_done_i`.
- R9: The hardware-autonomous-speed-disable bit (link-control data bit 11) is ignored: writing it alone changes no output.
- R10: `lsts_o` carries the status bit at position 15 and the speed at positions 3:0; every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| port_dsp_i | input | 1 | Port-type strap: 1 downstream-facing, 0 upstream-facing |
| reg_unlock_i | input | 1 | Register-unlock control bit |
| lctl_we_i | input | 1 | Write strobe for the link control register |
| lsts_we_i | input | 1 | Write strobe for the link status register |
| phyls_we_i | input | 1 | Write strobe for the PHY link state register |
| wr_data_i | input | 16 | Write data shared by the three strobes |
| partner_up_i | input | 1 | Link partner requests a speed upgrade |
| train_done_i | input | 1 | Training completed this cycle |
| train_speed_i | input | 4 | Speed reached by the completed training |
| go_recovery_o | output | 1 | Request pulse: enter training at Recovery |
| go_detect_o | output | 1 | Request pulse: enter training at Detect |
| speed_cap_o | output | 4 | Highest speed the training machine may use |
| lsts_o | output | 16 | Link status register image |

## Verification
The assertions check on every cycle that the request pulses follow their write strobes with the unlock gating and the Detect priority, and that the two pulses are mutually exclusive. They also check that a completion updates the speed and that a lowered speed cap stays lowered while no release event occurs. The status bit's set, clear and set-over-clear behaviour is checked on every cycle as well. Only the bench scenarios show the release timing of the speed cap after an issued Recovery pulse, and that a write of the ignored speed-disable bit leaves every output untouched. They also show that upstream-type ports never raise the status bit across a sequence of downgrades.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

    typedef logic [3:0] speed_t;

    localparam speed_t SPD_2G5 = 4'd1;
    localparam speed_t SPD_5G0 = 4'd2;

    // write-data bit positions decoded by this block
    localparam int LRET_BIT = 5;   // link control: retrain to Recovery
    localparam int HASD_BIT = 11;  // link control: ignored, reads zero
    localparam int FRET_BIT = 0;   // PHY state: full retrain to Detect
    localparam int BWS_BIT  = 15;  // link status: bandwidth-change status
    localparam int CLS_W    = 4;   // link status: current speed width

endpackage

// File: rtl/lrc_cmd_dec.sv
module lrc_cmd_dec (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic port_dsp_i,
    input  logic reg_unlock_i,
    input  logic lctl_we_i,
    input  logic lret_bit_i,
    input  logic phyls_we_i,
    input  logic fret_bit_i,
    output logic go_rec_o,
    output logic go_det_o
);

    typedef struct packed {
        logic rec;
        logic det;
    } cmd_st_t;

    cmd_st_t st_d, st_q;
    logic    lret_hit, fret_hit, lret_ok;

    always_comb begin
        lret_hit = lctl_we_i & lret_bit_i;
        fret_hit = phyls_we_i & fret_bit_i;
        // upstream ports need the unlock bit, downstream ports do not
        lret_ok  = lret_hit & (port_dsp_i | reg_unlock_i);
        st_d     = '0;
        st_d.det = fret_hit;
        st_d.rec = lret_ok & ~fret_hit;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign go_rec_o = st_q.rec;
    assign go_det_o = st_q.det;

    p_locked_up_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lctl_we_i && lret_bit_i && !port_dsp_i && !reg_unlock_i) |=> !go_rec_o);

    p_down_any_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lctl_we_i && lret_bit_i && port_dsp_i && !(phyls_we_i && fret_bit_i)) |=> go_rec_o);

    p_full_detect_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phyls_we_i && fret_bit_i) |=> (go_det_o && !go_rec_o));

    p_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({go_rec_o, go_det_o}));

    p_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (go_rec_o && !(lctl_we_i && lret_bit_i)) |=> !go_rec_o);

endmodule

// File: rtl/lrc_speed_trk.sv
module lrc_speed_trk
    import lrc_pkg::*;
#(
    parameter speed_t TGT_SPEED = SPD_5G0
) (
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   train_done_i,
    input  speed_t train_speed_i,
    input  logic   partner_up_i,
    input  logic   go_rec_i,
    input  logic   go_det_i,
    output speed_t cur_speed_o,
    output speed_t speed_cap_o,
    output logic   dngr_o
);

    typedef struct packed {
        speed_t cur;
        logic   lock;
    } spd_st_t;

    spd_st_t st_d, st_q;
    logic    release_ev;

    always_comb begin
        st_d       = st_q;
        dngr_o     = train_done_i && (st_q.cur == SPD_5G0) && (train_speed_i == SPD_2G5);
        release_ev = partner_up_i | go_rec_i | go_det_i;
        if (train_done_i) begin
            st_d.cur = train_speed_i;
        end
        if (dngr_o) begin
            st_d.lock = 1'b1;
        end else if (release_ev) begin
            st_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cur  <= TGT_SPEED;
            st_q.lock <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_speed_o = st_q.cur;
    assign speed_cap_o = st_q.lock ? SPD_2G5 : TGT_SPEED;

    p_cur_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        train_done_i |=> (cur_speed_o == $past(train_speed_i)));

    p_cur_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !train_done_i |=> $stable(cur_speed_o));

    p_cap_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (train_done_i && cur_speed_o == SPD_5G0 && train_speed_i == SPD_2G5) |=> (speed_cap_o == SPD_2G5));

    p_cap_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (speed_cap_o == SPD_2G5 && !partner_up_i && !go_rec_i && !go_det_i) |=> (speed_cap_o == SPD_2G5));

endmodule

// File: rtl/lrc_bw_sts.sv
module lrc_bw_sts (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic dngr_i,
    input  logic port_dsp_i,
    input  logic clr_i,
    output logic bw_o
);

    typedef struct packed {
        logic bw;
    } bw_st_t;

    bw_st_t st_d, st_q;
    logic   set_ev;

    always_comb begin
        set_ev = dngr_i & port_dsp_i;
        st_d   = st_q;
        if (set_ev) begin
            st_d.bw = 1'b1;          // a new event beats a same-cycle clear
        end else if (clr_i) begin
            st_d.bw = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bw_o = st_q.bw;

    p_set_dsp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dngr_i && port_dsp_i) |=> bw_o);

    p_no_set_ups_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bw_o && !(dngr_i && port_dsp_i)) |=> !bw_o);

    p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !(dngr_i && port_dsp_i)) |=> !bw_o);

    p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bw_o && !clr_i) |=> bw_o);

endmodule

// File: rtl/lnk_retrain_ctrl.sv
module lnk_retrain_ctrl
    import lrc_pkg::*;
#(
    parameter int     DATA_W    = 16,
    parameter speed_t TGT_SPEED = SPD_5G0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              port_dsp_i,
    input  logic              reg_unlock_i,
    input  logic              lctl_we_i,
    input  logic              lsts_we_i,
    input  logic              phyls_we_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              partner_up_i,
    input  logic              train_done_i,
    input  logic [3:0]        train_speed_i,
    output logic              go_recovery_o,
    output logic              go_detect_o,
    output logic [3:0]        speed_cap_o,
    output logic [DATA_W-1:0] lsts_o
);

    localparam int STS_W = DATA_W;

    logic   go_rec, go_det, dngr, bw;
    speed_t cur_speed, cap;
    logic   unused_wr_bits;

    // the speed-disable bit and all undefined bits are dropped here
    assign unused_wr_bits = ^{wr_data_i, wr_data_i[HASD_BIT]};

    lrc_cmd_dec u_cmd (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .port_dsp_i   (port_dsp_i),
        .reg_unlock_i (reg_unlock_i),
        .lctl_we_i    (lctl_we_i),
        .lret_bit_i   (wr_data_i[LRET_BIT]),
        .phyls_we_i   (phyls_we_i),
        .fret_bit_i   (wr_data_i[FRET_BIT]),
        .go_rec_o     (go_rec),
        .go_det_o     (go_det)
    );

    lrc_speed_trk #(
        .TGT_SPEED (TGT_SPEED)
    ) u_spd (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .train_done_i  (train_done_i),
        .train_speed_i (train_speed_i),
        .partner_up_i  (partner_up_i),
        .go_rec_i      (go_rec),
        .go_det_i      (go_det),
        .cur_speed_o   (cur_speed),
        .speed_cap_o   (cap),
        .dngr_o        (dngr)
    );

    lrc_bw_sts u_bw (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .dngr_i     (dngr),
        .port_dsp_i (port_dsp_i),
        .clr_i      (lsts_we_i & wr_data_i[BWS_BIT]),
        .bw_o       (bw)
    );

    always_comb begin
        lsts_o                = '0;
        lsts_o[CLS_W-1:0]     = cur_speed;
        lsts_o[BWS_BIT]       = bw;
    end

    assign go_recovery_o = go_rec;
    assign go_detect_o   = go_det;
    assign speed_cap_o   = cap;

    p_rsvd_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lsts_o & ~(STS_W'(1) << BWS_BIT) & ~STS_W'((1 << CLS_W) - 1)) == '0);

endmodule

// File: tb/lnk_retrain_ctrl_tb.sv
module lnk_retrain_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dsp = 1'b0, unlock = 1'b0;
    logic        lctl_we = 1'b0, lsts_we = 1'b0, phy_we = 1'b0;
    logic [15:0] wd = '0;
    logic        up = 1'b0, done = 1'b0;
    logic [3:0]  tspd = 4'd0;
    logic        go_rec, go_det;
    logic [3:0]  cap;
    logic [15:0] lsts;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    int m_rec, m_det, m_speed, m_lock, m_bw;

    always #4 clk = ~clk;

    lnk_retrain_ctrl u_dut (
        .clk_i (clk), .rst_ni (rst_n), .port_dsp_i (dsp), .reg_unlock_i (unlock),
        .lctl_we_i (lctl_we), .lsts_we_i (lsts_we), .phyls_we_i (phy_we),
        .wr_data_i (wd), .partner_up_i (up), .train_done_i (done),
        .train_speed_i (tspd), .go_recovery_o (go_rec), .go_detect_o (go_det),
        .speed_cap_o (cap), .lsts_o (lsts)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model, stepped on each rising edge from the inputs driven before it
    always @(posedge clk) begin
        int n_rec, n_det, n_lock, n_speed, n_bw;
        bit dn;
        if (!rst_n) begin
            m_rec = 0; m_det = 0; m_speed = 2; m_lock = 0; m_bw = 0;
        end else begin
            n_det   = (phy_we && wd[0]) ? 1 : 0;
            n_rec   = (lctl_we && wd[5] && (dsp || unlock) && n_det == 0) ? 1 : 0;
            dn      = done && m_speed == 2 && tspd == 1;
            n_lock  = dn ? 1 : ((up || m_rec == 1 || m_det == 1) ? 0 : m_lock);
            n_speed = done ? int'(tspd) : m_speed;
            n_bw    = (dn && dsp) ? 1 : ((lsts_we && wd[15]) ? 0 : m_bw);
            m_rec = n_rec; m_det = n_det; m_lock = n_lock; m_speed = n_speed; m_bw = n_bw;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 R2 go_recovery per-cycle", int'(go_rec), m_rec);
            chk("R3 go_detect per-cycle", int'(go_det), m_det);
            chk("R8 R5 R6 R10 status image per-cycle", int'(lsts), (m_bw << 15) | m_speed);
            chk("R7 speed cap per-cycle", int'(cap), (m_lock != 0) ? 1 : 2);
        end
    end

    task automatic idle();
        lctl_we = 0; lsts_we = 0; phy_we = 0; wd = '0; up = 0; done = 0; tspd = 0;
    endtask

    // drive for one cycle; on return the registered effect is visible
    task automatic wr_lctl(input logic [15:0] d);
        @(negedge clk); lctl_we = 1; wd = d;
        @(negedge clk); idle();
    endtask

    task automatic wr_phy(input logic [15:0] d);
        @(negedge clk); phy_we = 1; wd = d;
        @(negedge clk); idle();
    endtask

    task automatic wr_lsts(input logic [15:0] d);
        @(negedge clk); lsts_we = 1; wd = d;
        @(negedge clk); idle();
    endtask

    task automatic train(input logic [3:0] s);
        @(negedge clk); done = 1; tspd = s;
        @(negedge clk); idle();
    endtask

    task automatic partner();
        @(negedge clk); up = 1;
        @(negedge clk); idle();
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        chk("R8 reset speed", int'(lsts[3:0]), 2);
        chk("R6 reset status", int'(lsts[15]), 0);
        chk("R7 reset cap", int'(cap), 2);
        chk("R4 reset pulses", int'({go_rec, go_det}), 0);

        // upstream, locked
        dsp = 0; unlock = 0;
        wr_lctl(16'h0020);
        chk("R1 locked upstream ignored", int'(go_rec), 0);
        // upstream, unlocked
        unlock = 1;
        wr_lctl(16'h0020);
        chk("R1 unlocked upstream issues", int'(go_rec), 1);
        @(negedge clk);
        chk("R4 recovery single cycle", int'(go_rec), 0);

        // downstream, unlock low
        dsp = 1; unlock = 0;
        wr_lctl(16'h0020);
        chk("R2 downstream issues", int'(go_rec), 1);

        // full retrain on upstream port
        dsp = 0;
        wr_phy(16'h0001);
        chk("R3 full retrain detect", int'(go_det), 1);
        chk("R4 no recovery with detect", int'(go_rec), 0);

        // both written together on a downstream port
        dsp = 1;
        @(negedge clk); lctl_we = 1; phy_we = 1; wd = 16'h0021;
        @(negedge clk); idle();
        chk("R4 priority detect", int'(go_det), 1);
        chk("R4 priority no recovery", int'(go_rec), 0);

        // speed-disable bit write
        @(negedge clk);
        wr_lctl(16'h0800);
        chk("R9 speed-disable pulses", int'({go_rec, go_det}), 0);
        chk("R9 speed-disable status", int'(lsts), 2);
        chk("R9 speed-disable cap", int'(cap), 2);

        // downgrade on downstream port
        train(4'd1);
        chk("R5 downgrade sets status", int'(lsts[15]), 1);
        chk("R8 speed follows", int'(lsts[3:0]), 1);
        chk("R7 cap lowered", int'(cap), 1);
        chk("R10 image", int'(lsts), 16'h8001);

        // clear without bit 15 does nothing, with bit 15 clears
        wr_lsts(16'h4000);
        chk("R6 no clear without bit", int'(lsts[15]), 1);
        wr_lsts(16'h8000);
        chk("R6 write-one clears", int'(lsts[15]), 0);

        // back at 5.0 while cap held, then set and clear in same cycle
        train(4'd2);
        chk("R7 cap held after upgrade report", int'(cap), 1);
        @(negedge clk); done = 1; tspd = 4'd1; lsts_we = 1; wd = 16'h8000;
        @(negedge clk); idle();
        chk("R6 set beats clear", int'(lsts[15]), 1);

        // partner upgrade releases
        partner();
        chk("R7 partner releases cap", int'(cap), 2);

        // release by recovery pulse
        wr_lsts(16'h8000);
        train(4'd2);
        train(4'd1);
        chk("R7 cap low again", int'(cap), 1);
        wr_lctl(16'h0020);
        chk("R7 cap during pulse", int'(cap), 1);
        @(negedge clk);
        chk("R7 cap after recovery", int'(cap), 2);

        // release by detect pulse
        train(4'd2);
        train(4'd1);
        wr_phy(16'h0001);
        @(negedge clk);
        chk("R7 cap after detect", int'(cap), 2);

        // upstream port downgrade keeps status clear
        wr_lsts(16'h8000);
        dsp = 0; unlock = 0;
        train(4'd2);
        train(4'd1);
        chk("R5 upstream no status", int'(lsts[15]), 0);
        chk("R7 upstream cap lowered", int'(cap), 1);
        // locked upstream retrain does not release
        wr_lctl(16'h0020);
        @(negedge clk);
        chk("R1 R7 locked write keeps cap", int'(cap), 1);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule